// File: doc/BRIEF.md
# Interval Timer Host Register Interface

This block is the processor-facing front end of a three-channel down-counting interval timer. A host reaches it through a 2-bit address, an 8-bit write bus, a combinational 8-bit read bus and single-cycle read and write strobes. Addresses 0 to 2 select the count port of one channel each. Address 3 takes a control byte that either programs a channel's operating mode, number format and byte access order, or captures that channel's running count for a stable readback.

The counter channels themselves sit outside this block. Each channel sends its live 16-bit count in on `live_cnt_i`. For each channel the block drives out the programmed mode and BCD flag, a one-cycle pulse when a complete new count is assembled (with the value on `load_val_o`), and a separate one-cycle pulse when only the first byte of a two-byte load has arrived, so that a channel can stop counting while it waits for the second byte.

Top module: `tmr_host_if`

## Requirements
- R1: After an asynchronous reset every channel reports mode 0, binary format, no load or first-byte pulse and no pending capture, with access set to low byte then high byte.
- R2: A control byte decodes as channel bits 7:6, access bits 5:4 (0 capture, 1 low byte only, 2 high byte only, 3 low then high), mode bits 3:1 and BCD bit 0. `mode_o` and `bcd_o` update one cycle after the write strobe. Mode field values 6 and 7 are reported as 2 and 3.
- R3: A control byte with channel field 3 changes no channel state.
- R4: In low-only access, a count write gives a one-cycle `load_o` pulse in the next cycle, with the value {8'h00, data}. In high-only access the value is {data, 8'h00}.
- R5: In low-then-high access, the first count write gives a one-cycle `first_byte_o` pulse and no load. The second gives `load_o` with {second, first}. Any programming control byte returns the write sequence to the low byte.
- R6: Count reads return bits 7:0 of the count in low-only access and bits 15:8 in high-only access. In low-then-high access they alternate, starting with the low byte, and any programming control byte restarts the sequence at the low byte.
- R7: A capture command (access 0) snapshots the channel's live count for readback while the live count keeps changing, and leaves mode, BCD and access unchanged.
- R8: A capture is released once the programmed byte sequence has been read (one byte for single-byte access, two for low-then-high). Until then, further capture commands to that channel are ignored.
- R9: Reads at address 3 return 8'h00.
- R10: A programming control byte (access not 0) discards a pending capture on its channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 2 | Register address (0-2 count ports, 3 control) |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe, one cycle per byte |
| rd_i | input | 1 | Read strobe, one cycle per byte |
| rdata_o | output | 8 | Read data, valid during the read strobe |
| live_cnt_i | input | 48 | Live count of each channel, channel n at bits 16n+15:16n |
| mode_o | output | 9 | Mode per channel, channel n at bits 3n+2:3n |
| bcd_o | output | 3 | BCD flag per channel |
| load_o | output | 3 | Complete count load pulse per channel |
| load_val_o | output | 48 | Loaded count per channel, valid with load_o |
| first_byte_o | output | 3 | First byte of a two-byte load pulse per channel |

## Verification
The assertions assume that the address, data and strobes are X-free after reset, hold steady around each rising edge, and carry at most one strobe per cycle, so that a read and a write never hit the same channel in one cycle. They also assume the channels keep `live_cnt_i` steady between edges. The bench drives every input on the falling edge, raises only one strobe at a time, and changes the live counts only in cycles with no strobe. Within these rules it walks the byte orderings, capture and release, and the ignored cases.

// File: rtl/tmr_host_pkg.sv
package tmr_host_pkg;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 2 * DATA_W;
  localparam int MODE_W = 3;

  typedef enum logic [1:0] {
    ACC_CAPT = 2'd0,
    ACC_LO   = 2'd1,
    ACC_HI   = 2'd2,
    ACC_PAIR = 2'd3
  } acc_e;

  // mode codes 6/7 alias 2/3
  function automatic logic [MODE_W-1:0] fold_mode(input logic [MODE_W-1:0] m);
    return (m[2:1] == 2'b11) ? {1'b0, m[1:0]} : m;
  endfunction
endpackage

// File: rtl/tmr_host_dec.sv
module tmr_host_dec
  import tmr_host_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic [NUM_CH-1:0] ctrl_hit_o,
  output logic              capt_o,
  output acc_e              acc_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              bcd_o,
  output logic [NUM_CH-1:0] cnt_we_o,
  output logic [NUM_CH-1:0] cnt_re_o
);
  localparam logic [1:0] CTRL_ADDR = 2'd3;

  logic ctrl_wr;
  assign ctrl_wr = wr_i && (addr_i == CTRL_ADDR);
  assign acc_o   = acc_e'(wdata_i[5:4]);
  assign capt_o  = (wdata_i[5:4] == 2'b00);
  assign mode_o  = fold_mode(wdata_i[3:1]);
  assign bcd_o   = wdata_i[0];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_hit
    assign ctrl_hit_o[g] = ctrl_wr && (wdata_i[7:6] == 2'(g));
    assign cnt_we_o[g]   = wr_i && (addr_i == 2'(g));
    assign cnt_re_o[g]   = rd_i && (addr_i == 2'(g));
  end
endmodule

// File: rtl/tmr_host_chan.sv
module tmr_host_chan
  import tmr_host_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic              capt_i,
  input  acc_e              acc_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              bcd_i,
  input  logic              cnt_we_i,
  input  logic              cnt_re_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  live_i,
  output logic [MODE_W-1:0] mode_o,
  output logic              bcd_o,
  output logic              load_o,
  output logic [CNT_W-1:0]  load_val_o,
  output logic              first_o,
  output logic [DATA_W-1:0] rbyte_o
);
  acc_e              acc_q;
  logic [MODE_W-1:0] mode_q;
  logic              bcd_q;
  logic              wr_tog_q, rd_tog_q;
  logic              held_q;
  logic [CNT_W-1:0]  hold_val_q;
  logic [DATA_W-1:0] lo_byte_q;
  logic              load_q, first_q;
  logic [CNT_W-1:0]  load_val_q;
  logic [CNT_W-1:0]  src;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q      <= ACC_PAIR;
      mode_q     <= '0;
      bcd_q      <= 1'b0;
      wr_tog_q   <= 1'b0;
      rd_tog_q   <= 1'b0;
      held_q     <= 1'b0;
      hold_val_q <= '0;
      lo_byte_q  <= '0;
      load_q     <= 1'b0;
      first_q    <= 1'b0;
      load_val_q <= '0;
    end else begin
      load_q  <= 1'b0;
      first_q <= 1'b0;
      if (ctrl_we_i) begin
        if (capt_i) begin
          if (!held_q) begin
            held_q     <= 1'b1;
            hold_val_q <= live_i;
          end
        end else begin
          acc_q    <= acc_i;
          mode_q   <= mode_i;
          bcd_q    <= bcd_i;
          wr_tog_q <= 1'b0;
          rd_tog_q <= 1'b0;
          held_q   <= 1'b0;
        end
      end
      if (cnt_we_i) begin
        unique case (acc_q)
          ACC_LO: begin
            load_val_q <= {{DATA_W{1'b0}}, wdata_i};
            load_q     <= 1'b1;
          end
          ACC_HI: begin
            load_val_q <= {wdata_i, {DATA_W{1'b0}}};
            load_q     <= 1'b1;
          end
          ACC_PAIR: begin
            if (!wr_tog_q) begin
              lo_byte_q <= wdata_i;
              first_q   <= 1'b1;
              wr_tog_q  <= 1'b1;
            end else begin
              load_val_q <= {wdata_i, lo_byte_q};
              load_q     <= 1'b1;
              wr_tog_q   <= 1'b0;
            end
          end
          default: ;
        endcase
      end
      if (cnt_re_i) begin
        unique case (acc_q)
          ACC_LO, ACC_HI: held_q <= 1'b0;
          ACC_PAIR: begin
            rd_tog_q <= ~rd_tog_q;
            if (rd_tog_q) held_q <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  assign src = held_q ? hold_val_q : live_i;

  always_comb begin
    unique case (acc_q)
      ACC_HI:   rbyte_o = src[CNT_W-1:DATA_W];
      ACC_PAIR: rbyte_o = rd_tog_q ? src[CNT_W-1:DATA_W] : src[DATA_W-1:0];
      default:  rbyte_o = src[DATA_W-1:0];
    endcase
  end

  assign mode_o     = mode_q;
  assign bcd_o      = bcd_q;
  assign load_o     = load_q;
  assign load_val_o = load_val_q;
  assign first_o    = first_q;
endmodule

// File: rtl/tmr_host_if.sv
module tmr_host_if
  import tmr_host_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [1:0]               addr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  input  logic                     wr_i,
  input  logic                     rd_i,
  output logic [DATA_W-1:0]        rdata_o,
  input  logic [NUM_CH*CNT_W-1:0]  live_cnt_i,
  output logic [NUM_CH*MODE_W-1:0] mode_o,
  output logic [NUM_CH-1:0]        bcd_o,
  output logic [NUM_CH-1:0]        load_o,
  output logic [NUM_CH*CNT_W-1:0]  load_val_o,
  output logic [NUM_CH-1:0]        first_byte_o
);
  logic [NUM_CH-1:0] ctrl_hit, cnt_we, cnt_re;
  logic              capt, dec_bcd;
  acc_e              dec_acc;
  logic [MODE_W-1:0] dec_mode;
  logic [DATA_W-1:0] rbyte [NUM_CH];

  tmr_host_dec #(.NUM_CH(NUM_CH)) u_dec (
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .wr_i       (wr_i),
    .rd_i       (rd_i),
    .ctrl_hit_o (ctrl_hit),
    .capt_o     (capt),
    .acc_o      (dec_acc),
    .mode_o     (dec_mode),
    .bcd_o      (dec_bcd),
    .cnt_we_o   (cnt_we),
    .cnt_re_o   (cnt_re)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    tmr_host_chan u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ctrl_we_i  (ctrl_hit[g]),
      .capt_i     (capt),
      .acc_i      (dec_acc),
      .mode_i     (dec_mode),
      .bcd_i      (dec_bcd),
      .cnt_we_i   (cnt_we[g]),
      .cnt_re_i   (cnt_re[g]),
      .wdata_i    (wdata_i),
      .live_i     (live_cnt_i[g*CNT_W +: CNT_W]),
      .mode_o     (mode_o[g*MODE_W +: MODE_W]),
      .bcd_o      (bcd_o[g]),
      .load_o     (load_o[g]),
      .load_val_o (load_val_o[g*CNT_W +: CNT_W]),
      .first_o    (first_byte_o[g]),
      .rbyte_o    (rbyte[g])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (addr_i == 2'(i)) rdata_o = rbyte[i];
  end
endmodule

// File: rtl/tmr_host_chk.sv
module tmr_host_chk
  import tmr_host_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [1:0]               addr_i,
  input logic [DATA_W-1:0]        wdata_i,
  input logic                     wr_i,
  input logic                     rd_i,
  input logic [DATA_W-1:0]        rdata_o,
  input logic [NUM_CH*CNT_W-1:0]  live_cnt_i,
  input logic [NUM_CH*MODE_W-1:0] mode_o,
  input logic [NUM_CH-1:0]        bcd_o,
  input logic [NUM_CH-1:0]        load_o,
  input logic [NUM_CH*CNT_W-1:0]  load_val_o,
  input logic [NUM_CH-1:0]        first_byte_o
);
  logic ctrl_wr;
  assign ctrl_wr = wr_i && (addr_i == 2'd3);

  assert_mode_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mode_o) |-> $past(ctrl_wr));

  assert_sel3_ignored_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && wdata_i[7:6] == 2'b11) |=> ($stable(mode_o) && $stable(bcd_o)));

  assert_capt_keeps_mode_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && wdata_i[5:4] == 2'b00) |=> ($stable(mode_o) && $stable(bcd_o)));

  assert_ctrl_reads_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == 2'd3) |-> (rdata_o == '0));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    assert_mode_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mode_o[g*MODE_W +: MODE_W] < 3'd6);

    assert_load_after_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_o[g] |-> $past(wr_i && addr_i == 2'(g)));

    assert_first_after_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      first_byte_o[g] |-> $past(wr_i && addr_i == 2'(g)));

    assert_first_load_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(first_byte_o[g] && load_o[g]));
  end
endmodule

bind tmr_host_if tmr_host_chk #(.NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/sim_tmr_host_if.sv
module sim_tmr_host_if;
  localparam int NCH = 3;
  localparam int NV  = 46;
  // op: 0 write, 1 read check, 2 set live, 3 write+load check, 4 write+first check, 5 mode/bcd check
  localparam logic [32:0] VEC [NV] = '{
    {3'd2, 2'd0, 8'h00, 16'h1234, 4'd6},
    {3'd2, 2'd1, 8'h00, 16'hABCD, 4'd6},
    {3'd2, 2'd2, 8'h00, 16'h5A0F, 4'd6},
    {3'd1, 2'd0, 8'h00, 16'h0034, 4'd6},  // R6 reset pair order
    {3'd1, 2'd0, 8'h00, 16'h0012, 4'd6},
    {3'd0, 2'd3, 8'h14, 16'h0000, 4'd2},  // R2 ch0 lo-only mode 2
    {3'd5, 2'd0, 8'h00, 16'h0004, 4'd2},
    {3'd1, 2'd0, 8'h00, 16'h0034, 4'd6},
    {3'd1, 2'd0, 8'h00, 16'h0034, 4'd6},
    {3'd3, 2'd0, 8'h55, 16'h0055, 4'd4},  // R4 lo-only
    {3'd0, 2'd3, 8'h67, 16'h0000, 4'd2},  // ch1 hi-only mode 3 bcd
    {3'd5, 2'd1, 8'h00, 16'h0007, 4'd2},
    {3'd1, 2'd1, 8'h00, 16'h00AB, 4'd6},
    {3'd3, 2'd1, 8'h9C, 16'h9C00, 4'd4},  // R4 hi-only
    {3'd0, 2'd3, 8'hBE, 16'h0000, 4'd2},  // ch2 pair mode 7 -> 3
    {3'd5, 2'd2, 8'h00, 16'h0006, 4'd2},
    {3'd4, 2'd2, 8'h11, 16'h0000, 4'd5},  // R5
    {3'd3, 2'd2, 8'h22, 16'h2211, 4'd5},
    {3'd4, 2'd2, 8'h33, 16'h0000, 4'd5},
    {3'd0, 2'd3, 8'hBE, 16'h0000, 4'd5},  // R5 toggle reset
    {3'd4, 2'd2, 8'h44, 16'h0000, 4'd5},
    {3'd3, 2'd2, 8'h66, 16'h6644, 4'd5},
    {3'd0, 2'd3, 8'hD4, 16'h0000, 4'd3},  // R3 select 3
    {3'd5, 2'd0, 8'h00, 16'h0004, 4'd3},
    {3'd5, 2'd1, 8'h00, 16'h0007, 4'd3},
    {3'd5, 2'd2, 8'h00, 16'h0006, 4'd3},
    {3'd1, 2'd0, 8'h00, 16'h0034, 4'd3},
    {3'd0, 2'd3, 8'h80, 16'h0000, 4'd7},  // R7 capture ch2
    {3'd2, 2'd2, 8'h00, 16'h0001, 4'd7},
    {3'd1, 2'd2, 8'h00, 16'h000F, 4'd7},
    {3'd5, 2'd2, 8'h00, 16'h0006, 4'd7},
    {3'd0, 2'd3, 8'h80, 16'h0000, 4'd8},  // R8 ignored recapture
    {3'd2, 2'd2, 8'h00, 16'h7788, 4'd8},
    {3'd1, 2'd2, 8'h00, 16'h005A, 4'd8},
    {3'd1, 2'd2, 8'h00, 16'h0088, 4'd8},
    {3'd1, 2'd2, 8'h00, 16'h0077, 4'd8},
    {3'd0, 2'd3, 8'h40, 16'h0000, 4'd7},  // capture ch1 hi-only
    {3'd2, 2'd1, 8'h00, 16'h1111, 4'd7},
    {3'd1, 2'd1, 8'h00, 16'h00AB, 4'd7},
    {3'd1, 2'd1, 8'h00, 16'h0011, 4'd8},
    {3'd2, 2'd0, 8'h00, 16'hFFEE, 4'd10}, // R10
    {3'd0, 2'd3, 8'h00, 16'h0000, 4'd10},
    {3'd2, 2'd0, 8'h00, 16'h0102, 4'd10},
    {3'd0, 2'd3, 8'h14, 16'h0000, 4'd10},
    {3'd1, 2'd0, 8'h00, 16'h0002, 4'd10},
    {3'd1, 2'd3, 8'h00, 16'h0000, 4'd9}   // R9
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        addr = '0;
  logic [7:0]        wdata = '0;
  logic              wr = 1'b0, rd = 1'b0;
  logic [7:0]        rdata;
  logic [NCH*16-1:0] live = '0;
  logic [NCH*3-1:0]  mode;
  logic [NCH-1:0]    bcd, load, first;
  logic [NCH*16-1:0] load_val;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tmr_host_if #(.NUM_CH(NCH)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .wr_i(wr), .rd_i(rd),
    .rdata_o(rdata), .live_cnt_i(live), .mode_o(mode), .bcd_o(bcd), .load_o(load),
    .load_val_o(load_val), .first_byte_o(first)
  );

  task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic do_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic do_rd(input logic [1:0] a, output logic [7:0] q);
    @(negedge clk); addr = a; rd = 1'b1;
    #1 q = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  initial begin
    logic [7:0] q;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(1, {23'd0, mode}, 32'd0);
    chk(1, {29'd0, bcd}, 32'd0);
    chk(1, {26'd0, load, first}, 32'd0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      logic [2:0] op; logic [1:0] a; logic [7:0] d; logic [15:0] e; int rq;
      {op, a, d, e} = VEC[i][32:4];
      rq = int'(VEC[i][3:0]);
      case (op)
        3'd0: do_wr(a, d);
        3'd1: begin do_rd(a, q); chk(rq, {24'd0, q}, {24'd0, e[7:0]}); end
        3'd2: begin @(negedge clk); live[a*16 +: 16] = e; end
        3'd3: begin
          do_wr(a, d);
          chk(rq, {15'd0, load[a], load_val[a*16 +: 16]}, {15'd0, 1'b1, e});
          chk(rq, {31'd0, first[a]}, 32'd0);
          @(negedge clk);
          chk(rq, {31'd0, load[a]}, 32'd0);
        end
        3'd4: begin
          do_wr(a, d);
          chk(rq, {30'd0, first[a], load[a]}, 32'd2);
        end
        default: chk(rq, {28'd0, mode[a*3 +: 3], bcd[a]}, {16'd0, e});
      endcase
    end
    // R1 directed: reset clears capture and settings mid-sequence
    do_wr(2'd3, 8'h80);
    @(negedge clk); live[32 +: 16] = 16'h1234;
    rst_n = 1'b0;
    #1;
    chk(1, {23'd0, mode}, 32'd0);
    chk(1, {29'd0, bcd}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    do_rd(2'd2, q);
    chk(1, {24'd0, q}, 32'h34);
    do_rd(2'd0, q);
    chk(1, {24'd0, q}, 32'h02);
    do_rd(2'd0, q);
    chk(1, {24'd0, q}, 32'h01);
    // R5 corner: pair load on ch0 after reset
    do_wr(2'd0, 8'hA5);
    chk(5, {30'd0, first[0], load[0]}, 32'd2);
    do_wr(2'd0, 8'h00);
    chk(5, {15'd0, load[0], load_val[15:0]}, {15'd0, 1'b1, 16'h00A5});
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule